// File: doc/BRIEF.md
# Link Controller Power-Up Sequencer

This block brings a serial-link controller and its PHY out of the powered-down, held-in-reset condition in a fixed order. It raises the supply enable, turns on the controller clock gates one per cycle, and takes the PHY out of power-down. After a short delay it enables the PHY reference clock, so that the PHY's internally synchronised reset lasts long enough. A settling interval follows. The sequencer then pulses the endpoint reset pin and releases the PHY reset. It polls a PLL-locked input with a bounded number of attempts, and finally releases the controller reset. When the block uses a software reset, a further wait follows that release.

Every delay is set in microseconds and converted to clock cycles through a cycles-per-microsecond parameter. If the PLL never reports lock within the retry budget, the sequencer parks with an error flag raised and never signals completion. A shutdown request, accepted in any state, returns every output to the powered-down, reset-asserted condition on the next cycle, which leaves the link down. A new start request is needed after that.

Top module: `lnk_pwrseq`

## Requirements
- R1: After reset, and while idle, the outputs are: `supply_en`=0, `phy_pwrdn`=1, `refclk_en`=0, all `clk_en` bits 0, `phy_rst`=1, `ctrl_rst`=1, `ep_rst_pin` at its asserted level, and `seq_done`=0 and `lock_err`=0.
- R2: A `start` pulse seen at clock edge E raises `supply_en` in the cycle after E. `clk_en[i]` then rises 1+i cycles after `supply_en`, and `phy_pwrdn` falls NUM_CLKS cycles after `clk_en[0]` rises.
- R3: `refclk_en` rises exactly REFCLK_DLY_US×CYC_PER_US cycles after `phy_pwrdn` falls, and it is never high while `phy_pwrdn` is high.
- R4: No reset is released until SETTLE_US×CYC_PER_US cycles after `refclk_en` rises. The endpoint pin then stays asserted for a further EP_PULSE_US×CYC_PER_US cycles. The endpoint pin and `phy_rst` are released in the same cycle.
- R5: The asserted level of `ep_rst_pin` is 1 when EP_ACT_HIGH=1 and 0 when EP_ACT_HIGH=0.
- R6: `pll_lock` is sampled in the cycle `phy_rst` falls and then once every POLL_US×CYC_PER_US+1 cycles. `ctrl_rst` falls in the cycle after the first sample that sees lock.
- R7: If MAX_POLLS samples all miss lock, `lock_err` rises one cycle after the last sample. In that case `ctrl_rst` stays high and `seq_done` stays low.
- R8: With USE_SW_RST=1, `seq_done` rises POST_RST_US×CYC_PER_US cycles after `ctrl_rst` falls. With USE_SW_RST=0 it rises one cycle after.
- R9: A `shutdown` seen at any edge puts every output back to its R1 value in the next cycle, including `seq_done` and `lock_err`. `shutdown` wins over `start`.
- R10: A `start` pulse while a sequence is in progress does not change any output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence (idle only) |
| shutdown | input | 1 | Return to the powered-down, reset-asserted state |
| pll_lock | input | 1 | PHY PLL locked indication |
| supply_en | output | 1 | Supply regulator enable |
| phy_pwrdn | output | 1 | PHY power-down, 1 = powered down |
| refclk_en | output | 1 | PHY reference clock enable |
| clk_en | output | NUM_CLKS | Controller clock gate enables, bit 0 first |
| phy_rst | output | 1 | PHY reset, 1 = held in reset |
| ctrl_rst | output | 1 | Controller reset, 1 = held in reset |
| ep_rst_pin | output | 1 | Endpoint reset pin, polarity set by EP_ACT_HIGH |
| seq_done | output | 1 | All steps complete |
| lock_err | output | 1 | PLL lock not seen within the retry budget |

## Verification
The assertions assume that `pll_lock` and `start` are synchronous to `clk`. They also assume that once `shutdown` is seen, the outputs are judged from the next cycle on. The bench drives every input only on the falling edge, so each input is stable at the rising edge.

The bench chooses the PLL lock moment at random, relative to the observed PHY reset release. It then predicts the poll sample that catches the lock, or predicts a timeout when no sample does. Shutdown arrives at a random point of a sequence, and stray `start` pulses arrive while a sequence is running. Two instances with opposite endpoint polarity and different software-reset settings run side by side on the same inputs.

// File: rtl/lnk_pwrseq_pkg.sv
package lnk_pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_OFF      = 4'd0,
        ST_SUPPLY   = 4'd1,
        ST_CLKS     = 4'd2,
        ST_PHY_UP   = 4'd3,
        ST_REFCLK   = 4'd4,
        ST_EP_HOLD  = 4'd5,
        ST_POLL     = 4'd6,
        ST_POLL_GAP = 4'd7,
        ST_CTRL_REL = 4'd8,
        ST_DONE     = 4'd9,
        ST_FAULT    = 4'd10
    } seq_state_t;

    typedef struct packed {
        logic supply_en;
        logic phy_pwrdn;
        logic refclk_en;
        logic clocks_on;
        logic phy_rst;
        logic ep_assert;
        logic ctrl_rst;
        logic done;
        logic err;
    } seq_out_t;

    // Microseconds to clock cycles, never below one cycle.
    function automatic int us2cyc(input int us, input int cyc_per_us);
        int v;
        v = us * cyc_per_us;
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Moore decode of the sequencer state into output levels.
    function automatic seq_out_t decode(input seq_state_t s);
        seq_out_t o;
        o.supply_en = (s != ST_OFF);
        o.phy_pwrdn = (s inside {ST_OFF, ST_SUPPLY, ST_CLKS});
        o.refclk_en = (s inside {ST_REFCLK, ST_EP_HOLD, ST_POLL, ST_POLL_GAP,
                                 ST_CTRL_REL, ST_DONE, ST_FAULT});
        o.clocks_on = !(s inside {ST_OFF, ST_SUPPLY, ST_CLKS});
        o.phy_rst   = (s inside {ST_OFF, ST_SUPPLY, ST_CLKS, ST_PHY_UP,
                                 ST_REFCLK, ST_EP_HOLD});
        o.ep_assert = o.phy_rst;
        o.ctrl_rst  = !(s inside {ST_CTRL_REL, ST_DONE});
        o.done      = (s == ST_DONE);
        o.err       = (s == ST_FAULT);
        return o;
    endfunction

endpackage

// File: rtl/lnk_pwrseq_timer.sv
module lnk_pwrseq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] cnt,
    output logic          zero
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign zero = (cnt == '0);

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - TW'(1))); // R3

endmodule

// File: rtl/lnk_pwrseq_retry.sv
module lnk_pwrseq_retry #(
    parameter int MAX_POLLS = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int RW = $clog2(MAX_POLLS + 1);

    logic [RW-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst || clr)
            tries <= '0;
        else if (inc && tries != RW'(MAX_POLLS - 1))
            tries <= tries + RW'(1);
    end

    assign last = (tries == RW'(MAX_POLLS - 1));

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        inc |=> (tries <= RW'(MAX_POLLS - 1))); // R7

endmodule

// File: rtl/lnk_pwrseq_fsm.sv
module lnk_pwrseq_fsm
    import lnk_pwrseq_pkg::*;
#(
    parameter int TW       = 16,
    parameter int CLKS_CYC = 3,
    parameter int REF_CYC  = 1250,
    parameter int SET_CYC  = 25000,
    parameter int EP_CYC   = 12500,
    parameter int POLL_CYC = 6250,
    parameter int POST_CYC = 25000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          shutdown,
    input  logic          pll_lock,
    input  logic          tmr_zero,
    input  logic          rty_last,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          rty_clr,
    output logic          rty_inc,
    output seq_state_t    state
);
    localparam logic [TW-1:0] V_CLKS = TW'(CLKS_CYC - 1);
    localparam logic [TW-1:0] V_REF  = TW'(REF_CYC - 1);
    localparam logic [TW-1:0] V_SET  = TW'(SET_CYC - 1);
    localparam logic [TW-1:0] V_EP   = TW'(EP_CYC - 1);
    localparam logic [TW-1:0] V_POLL = TW'(POLL_CYC - 1);
    localparam logic [TW-1:0] V_POST = TW'(POST_CYC - 1);

    seq_state_t nxt;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rty_clr  = 1'b0;
        rty_inc  = 1'b0;
        unique case (state)
            ST_OFF:      if (start) nxt = ST_SUPPLY;
            ST_SUPPLY: begin
                nxt = ST_CLKS; tmr_load = 1'b1; tmr_val = V_CLKS;
            end
            ST_CLKS: if (tmr_zero) begin
                nxt = ST_PHY_UP; tmr_load = 1'b1; tmr_val = V_REF;
            end
            ST_PHY_UP: if (tmr_zero) begin
                nxt = ST_REFCLK; tmr_load = 1'b1; tmr_val = V_SET;
            end
            ST_REFCLK: if (tmr_zero) begin
                nxt = ST_EP_HOLD; tmr_load = 1'b1; tmr_val = V_EP;
            end
            ST_EP_HOLD: if (tmr_zero) begin
                nxt = ST_POLL; rty_clr = 1'b1;
            end
            ST_POLL: begin
                if (pll_lock) begin
                    nxt = ST_CTRL_REL; tmr_load = 1'b1; tmr_val = V_POST;
                end else if (rty_last) begin
                    nxt = ST_FAULT;
                end else begin
                    nxt = ST_POLL_GAP; rty_inc = 1'b1;
                    tmr_load = 1'b1; tmr_val = V_POLL;
                end
            end
            ST_POLL_GAP: if (tmr_zero) nxt = ST_POLL;
            ST_CTRL_REL: if (tmr_zero) nxt = ST_DONE;
            ST_DONE:     nxt = ST_DONE;
            ST_FAULT:    nxt = ST_FAULT;
            default:     nxt = ST_OFF;
        endcase
        if (shutdown) begin
            nxt      = ST_OFF;
            tmr_load = 1'b0;
            rty_clr  = 1'b1;
            rty_inc  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= nxt;
    end

    AST_SHUTDOWN_TO_OFF: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> (state == ST_OFF)); // R9
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_OFF && state != ST_SUPPLY) |=> (state != ST_SUPPLY)); // R10
    AST_FAULT_NEEDS_POLL: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_FAULT) |-> ($past(state) == ST_POLL && !$past(pll_lock))); // R7

endmodule

// File: rtl/lnk_pwrseq.sv
module lnk_pwrseq
    import lnk_pwrseq_pkg::*;
#(
    parameter int CYC_PER_US    = 125,
    parameter int NUM_CLKS      = 3,
    parameter int REFCLK_DLY_US = 10,
    parameter int SETTLE_US     = 200,
    parameter int EP_PULSE_US   = 100,
    parameter int POLL_US       = 50,
    parameter int MAX_POLLS     = 2000,
    parameter int POST_RST_US   = 200,
    parameter bit USE_SW_RST    = 1'b1,
    parameter bit EP_ACT_HIGH   = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                shutdown,
    input  logic                pll_lock,
    output logic                supply_en,
    output logic                phy_pwrdn,
    output logic                refclk_en,
    output logic [NUM_CLKS-1:0] clk_en,
    output logic                phy_rst,
    output logic                ctrl_rst,
    output logic                ep_rst_pin,
    output logic                seq_done,
    output logic                lock_err
);
    localparam int REF_CYC  = us2cyc(REFCLK_DLY_US, CYC_PER_US);
    localparam int SET_CYC  = us2cyc(SETTLE_US, CYC_PER_US);
    localparam int EP_CYC   = us2cyc(EP_PULSE_US, CYC_PER_US);
    localparam int POLL_CYC = us2cyc(POLL_US, CYC_PER_US);
    localparam int POST_CYC = USE_SW_RST ? us2cyc(POST_RST_US, CYC_PER_US) : 1;
    localparam int MAX_CYC  = max2(max2(max2(REF_CYC, SET_CYC), max2(EP_CYC, POLL_CYC)),
                                   max2(POST_CYC, NUM_CLKS));
    localparam int TW       = $clog2(MAX_CYC + 1);

    seq_state_t    state;
    seq_out_t      dec;
    logic          tmr_load, tmr_zero, rty_clr, rty_inc, rty_last;
    logic [TW-1:0] tmr_val, tmr_cnt;

    lnk_pwrseq_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .cnt(tmr_cnt), .zero(tmr_zero)
    );

    lnk_pwrseq_retry #(.MAX_POLLS(MAX_POLLS)) u_retry (
        .clk(clk), .rst(rst), .clr(rty_clr), .inc(rty_inc), .last(rty_last)
    );

    lnk_pwrseq_fsm #(
        .TW(TW), .CLKS_CYC(NUM_CLKS), .REF_CYC(REF_CYC), .SET_CYC(SET_CYC),
        .EP_CYC(EP_CYC), .POLL_CYC(POLL_CYC), .POST_CYC(POST_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .shutdown(shutdown),
        .pll_lock(pll_lock), .tmr_zero(tmr_zero), .rty_last(rty_last),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .rty_clr(rty_clr),
        .rty_inc(rty_inc), .state(state)
    );

    assign dec = decode(state);

    // Clock gates open one per cycle while the count runs down in ST_CLKS.
    for (genvar g = 0; g < NUM_CLKS; g++) begin : g_clk_gate
        assign clk_en[g] = dec.clocks_on ||
                           (state == ST_CLKS && tmr_cnt <= TW'(NUM_CLKS - 1 - g));
    end

    assign supply_en  = dec.supply_en;
    assign phy_pwrdn  = dec.phy_pwrdn;
    assign refclk_en  = dec.refclk_en;
    assign phy_rst    = dec.phy_rst;
    assign ctrl_rst   = dec.ctrl_rst;
    assign ep_rst_pin = EP_ACT_HIGH ? dec.ep_assert : !dec.ep_assert;
    assign seq_done   = dec.done;
    assign lock_err   = dec.err;

    AST_CLK_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        (clk_en != '0) |-> supply_en); // R2
    AST_REF_AFTER_PWRUP: assert property (@(posedge clk) disable iff (rst)
        $rose(refclk_en) |-> ($past(!phy_pwrdn) && !phy_pwrdn)); // R3
    AST_RST_AFTER_REF: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_rst) |-> ($past(refclk_en) && clk_en == {NUM_CLKS{1'b1}})); // R4
    AST_CTRL_AFTER_PHY: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_rst) |-> ($past(!phy_rst) && pll_lock == $past(pll_lock) || $past(pll_lock))); // R6
    AST_DONE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> ($past(!ctrl_rst) && !lock_err)); // R8
    AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> (!supply_en && phy_pwrdn && phy_rst && ctrl_rst && !seq_done && !lock_err)); // R9

endmodule

// File: tb/lnk_pwrseq_tb_top.sv
module lnk_pwrseq_tb_top;
    localparam int CPU = 2, NC = 3;
    localparam int REF_US = 3, SET_US = 5, EP_US = 4, POLL_US = 2, MAXP = 6, POST_US = 3;

    function automatic int cyc(input int us);
        return (us * CPU < 1) ? 1 : us * CPU;
    endfunction

    localparam int REF = REF_US * CPU, SET = SET_US * CPU, EPC = EP_US * CPU;
    localparam int P = POLL_US * CPU, POST = POST_US * CPU;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, shutdown = 1'b0, pll_lock = 1'b0;
    logic sup, pd, ref_en, prst, crst, ep, dn, er;
    logic [NC-1:0] ce;
    logic a_sup, a_pd, a_ref, a_prst, a_crst, a_ep, a_dn, a_er;
    logic [NC-1:0] a_ce;

    int n_chk = 0, n_fail = 0, cyc_n = 0;
    bit finished = 1'b0;

    always #4 clk = !clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    lnk_pwrseq #(.CYC_PER_US(CPU), .NUM_CLKS(NC), .REFCLK_DLY_US(REF_US), .SETTLE_US(SET_US),
        .EP_PULSE_US(EP_US), .POLL_US(POLL_US), .MAX_POLLS(MAXP), .POST_RST_US(POST_US),
        .USE_SW_RST(1'b1), .EP_ACT_HIGH(1'b1)) dut_i (
        .clk(clk), .rst(rst), .start(start), .shutdown(shutdown), .pll_lock(pll_lock),
        .supply_en(sup), .phy_pwrdn(pd), .refclk_en(ref_en), .clk_en(ce), .phy_rst(prst),
        .ctrl_rst(crst), .ep_rst_pin(ep), .seq_done(dn), .lock_err(er));

    lnk_pwrseq #(.CYC_PER_US(CPU), .NUM_CLKS(NC), .REFCLK_DLY_US(REF_US), .SETTLE_US(SET_US),
        .EP_PULSE_US(EP_US), .POLL_US(POLL_US), .MAX_POLLS(MAXP), .POST_RST_US(POST_US),
        .USE_SW_RST(1'b0), .EP_ACT_HIGH(1'b0)) dut_alt_i (
        .clk(clk), .rst(rst), .start(start), .shutdown(shutdown), .pll_lock(pll_lock),
        .supply_en(a_sup), .phy_pwrdn(a_pd), .refclk_en(a_ref), .clk_en(a_ce), .phy_rst(a_prst),
        .ctrl_rst(a_crst), .ep_rst_pin(a_ep), .seq_done(a_dn), .lock_err(a_er));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_off(input string req);
        chk(!sup && pd && !ref_en && ce == '0 && prst && crst && ep && !dn && !er,
            req, {sup, pd, ref_en, ce, prst, crst, ep, dn, er}, 11'b01000011100);
        chk(!a_sup && a_pd && a_ce == '0 && a_prst && a_crst && !a_ep && !a_dn && !a_er,
            {req, " alt"}, {a_ep, a_dn, a_er}, 3'b000);
    endtask

    // One full sequence; lock raised r cycles after PHY reset release (r<0: never).
    task automatic run_seq(input int r, input bit poke);
        int s, t_sup, t_pd, t_ref, t_ep, t_phy, t_ctl, t_dn, t_er, ta_ep, ta_dn, t_lk;
        int t_ce[NC];
        int i_exp;
        @(negedge clk);
        start = 1'b1; s = cyc_n;
        t_sup = -1; t_pd = -1; t_ref = -1; t_ep = -1; t_phy = -1; t_ctl = -1;
        t_dn = -1; t_er = -1; ta_ep = -1; ta_dn = -1; t_lk = -1;
        foreach (t_ce[k]) t_ce[k] = -1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            start = (poke && cyc_n == s + 12) ? 1'b1 : 1'b0;
            if (sup && t_sup < 0) t_sup = cyc_n;
            for (int g = 0; g < NC; g++) if (ce[g] && t_ce[g] < 0) t_ce[g] = cyc_n;
            if (!pd && t_pd < 0) t_pd = cyc_n;
            if (ref_en && t_ref < 0) t_ref = cyc_n;
            if (!ep && t_ep < 0) t_ep = cyc_n;
            if (a_ep && ta_ep < 0) ta_ep = cyc_n;
            if (!prst && t_phy < 0) begin t_phy = cyc_n; if (r >= 0) t_lk = cyc_n + r; end
            if (t_lk >= 0 && cyc_n == t_lk) pll_lock = 1'b1;
            if (!crst && t_ctl < 0) t_ctl = cyc_n;
            if (dn && t_dn < 0) t_dn = cyc_n;
            if (a_dn && ta_dn < 0) ta_dn = cyc_n;
            if (er && t_er < 0) t_er = cyc_n;
            if ((t_dn >= 0 || t_er >= 0) && (ta_dn >= 0 || a_er)) break;
        end
        chk(t_sup == s + 1, "R2 supply", t_sup, s + 1);
        for (int g = 0; g < NC; g++) chk(t_ce[g] == s + 2 + g, "R2 clk gate", t_ce[g], s + 2 + g);
        chk(t_pd == s + 2 + NC, "R2 pwrdn release", t_pd, s + 2 + NC);
        chk(t_ref == t_pd + cyc(REF_US), "R3 refclk delay", t_ref - t_pd, REF);
        chk(t_ep == t_ref + SET + EPC, "R4 endpoint release", t_ep - t_ref, SET + EPC);
        chk(t_phy == t_ep, "R4 phy with endpoint", t_phy, t_ep);
        chk(ta_ep == t_ep, "R5 active-low endpoint", ta_ep, t_ep);
        if (r >= 0 && (r + P) / (P + 1) < MAXP) begin
            i_exp = (r + P) / (P + 1);
            chk(t_ctl == t_phy + i_exp * (P + 1) + 1, "R6 lock sample", t_ctl - t_phy,
                i_exp * (P + 1) + 1);
            chk(t_dn == t_ctl + POST, "R8 sw reset wait", t_dn - t_ctl, POST);
            chk(ta_dn == t_ctl + 1, "R8 no sw reset", ta_dn - t_ctl, 1);
            chk(t_er < 0, "R7 no error on lock", t_er, -1);
        end else begin
            chk(t_er == t_phy + MAXP + (MAXP - 1) * P, "R7 timeout", t_er - t_phy,
                MAXP + (MAXP - 1) * P);
            chk(t_dn < 0 && crst && a_er, "R7 no done on timeout", {dn, crst}, 2'b01);
        end
        if (poke) chk(t_sup == s + 1 && t_ref == t_pd + REF, "R10 start ignored", t_ref - t_pd, REF);
    endtask

    task automatic do_shutdown(input string req);
        @(negedge clk);
        shutdown = 1'b1;
        @(negedge clk);
        shutdown = 1'b0; pll_lock = 1'b0;
        chk_off(req);
    endtask

    initial begin
        void'($urandom(32'h5EED_0421));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_off("R1 reset state");
        run_seq(0, 1'b0);
        do_shutdown("R9 shutdown from done");
        for (int n = 0; n < 5; n++) begin
            run_seq(int'($urandom_range(1, (MAXP - 1) * (P + 1))), n == 2);
            do_shutdown("R9 shutdown from done");
        end
        run_seq(-1, 1'b0);
        do_shutdown("R9 shutdown from fault");
        run_seq((MAXP - 1) * (P + 1) + 1, 1'b0);
        do_shutdown("R9 shutdown after late lock");
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat ($urandom_range(1, 40)) @(negedge clk);
            shutdown = 1'b1; start = 1'b1;
            @(negedge clk);
            shutdown = 1'b0; start = 1'b0;
            chk_off("R9 shutdown mid sequence");
            @(negedge clk);
            chk_off("R1 idle stays off");
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule